// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind a two-wire memory protocol engine and turns one write transaction into a single page update of an on-chip byte array. The engine opens a transaction with a starting word address. It then strobes in data bytes, and closes the transaction with a commit strobe when the bus stop arrives. The bytes land in a page-sized latch that tracks which entries were written. The write pointer advances only in its low bits, so a long burst folds back to the start of the same page instead of moving on to the next page.

On commit, the sequencer walks the whole page. It reads each old byte and writes back either that old byte or the buffered one, so every byte of the page goes through the cycle even when only one was written. It then holds busy for a programmable number of clocks that stands in for the self-timed programming delay. Pages in the top eighth of the array are never altered. A separate read port returns array bytes one clock after the address and is unaffected by the protection.

Top module: `pwb_page_writer`

## Requirements
- R1: While rst_n is low at a clock edge, busy is low after that edge, and no transaction is open after reset.
- R2: Before any write, the array byte at address a reads as a[7:0] XOR 8'h5A. rd_data shows the byte at the rd_addr sampled one clock edge earlier, for every address including protected ones.
- R3: txn_start (when not busy) latches the page number start_addr[ADDR_W-1:PAGE_W] and the in-page offset start_addr[PAGE_W-1:0]. Each accepted byte is stored at the current offset, and then only the offset's low PAGE_W bits increment, so offset 63 is followed by offset 0 of the same page.
- R4: If more than 64 bytes are pushed in one transaction, a later byte replaces the earlier byte buffered at the same offset.
- R5: A commit with at least one byte buffered raises busy at the next edge and holds it for exactly 2^PAGE_W + 1 + CYC_LEN clock cycles. After busy falls, the array holds the new bytes.
- R6: Offsets of the page that were not pushed in the transaction keep their previous array contents after the commit.
- R7: A page whose top three address bits are all ones is write-protected: a commit into it leaves the array unchanged, while busy timing is as in R5.
- R8: A commit with no byte pushed since txn_start never raises busy and changes nothing.
- R9: txn_start, byte_push and commit are ignored while busy is high; in particular a commit during busy does not extend it, and a start during busy opens no transaction.
- R10: Each accepted txn_start clears the written-byte record, so a later transaction to the same page changes only the offsets it pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start | input | 1 | Open a write transaction at start_addr |
| start_addr | input | ADDR_W | Starting word address of the transaction |
| byte_push | input | 1 | Strobe: push_data is the next data byte |
| push_data | input | 8 | Data byte to buffer |
| commit | input | 1 | Stop strobe: commit the buffered page |
| busy | output | 1 | Page copy or timed write cycle in progress |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte for the previous rd_addr |

## Verification
A scoreboard keeps a model of the array and compares the whole affected page after each commit. The single-byte write tells whether neighbouring bytes survive the rewrite. The 64-byte burst starting mid-page tells a wrapping pointer from one that spills into the next page, and the 70-byte burst tells whether the overflow replaces the earliest bytes. Empty commits, writes into the protected zone, and strobes issued during busy separate "no cycle", "cycle without effect" and "ignored" behaviour. A second write to an already-written page shows whether the written-byte record was cleared.

// File: rtl/pwb_pkg.sv
// Shared types for the page write buffer.
package pwb_pkg;
    // Sequencer phase: idle, page read-modify-write copy, timed wait.
    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_COPY = 2'd1,
        PW_WAIT = 2'd2
    } pw_state_t;
endpackage

// File: rtl/pwb_array.sv
// Byte array with one write port and two registered read ports.
// Assumes: contents come up with a computed pattern (a[7:0] ^ 8'h5A)
// standing in for factory data; no reset on storage.
module pwb_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic [ADDR_W-1:0] int_rd_addr,
    output logic [7:0]        old_byte,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [7:0]        wd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Power-up contents computed from the address.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
        end
    end

    // Write port and both registered read ports.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
        rd_data  <= mem[rd_addr];
        old_byte <= mem[int_rd_addr];
    end
endmodule

// File: rtl/pwb_latch.sv
// Page latch: one byte per page offset plus a written-byte mask.
// Assumes: the controller gates push_en and clear; the pointer wraps
// naturally in PAGE_W bits.
module pwb_latch #(
    parameter int PAGE_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic [PAGE_W-1:0]        start_off,
    input  logic                     push_en,
    input  logic [7:0]               push_byte,
    input  logic [PAGE_W-1:0]        rd_idx,
    output logic [7:0]               rd_byte,
    output logic                     rd_dirty,
    output logic                     any_dirty,
    output logic [PAGE_W-1:0]        ptr_q,
    output logic [(1<<PAGE_W)-1:0]   dirty_q
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0] lat [PAGE_BYTES];

    // Data entries: store the pushed byte at the pointer.
    always_ff @(posedge clk) begin
        if (push_en) begin
            lat[ptr_q] <= push_byte;
        end
    end

    // Pointer and written-byte mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            dirty_q <= '0;
        end else if (clear) begin
            ptr_q   <= start_off;
            dirty_q <= '0;
        end else if (push_en) begin
            ptr_q          <= ptr_q + 1'b1;
            dirty_q[ptr_q] <= 1'b1;
        end
    end

    // Lookup for the commit sequencer.
    always_comb begin
        rd_byte   = lat[rd_idx];
        rd_dirty  = dirty_q[rd_idx];
        any_dirty = |dirty_q;
    end
endmodule

// File: rtl/pwb_ctrl.sv
// Transaction and commit sequencer. Accepts start/push/commit while idle,
// then copies the page (read old, write merged) and waits CYC_LEN clocks.
// Assumes: one array read per clock with one clock of latency.
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int PAGE_W  = 6,
    parameter int CYC_LEN = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_push,
    input  logic              commit,
    input  logic              any_dirty,
    input  logic [7:0]        lat_byte,
    input  logic              lat_dirty,
    input  logic [7:0]        old_byte,
    output logic              busy,
    output logic              open_q,
    output logic              clear,
    output logic              push_en,
    output logic [PAGE_W-1:0] lat_idx,
    output logic [ADDR_W-1:0] int_rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    localparam int PG_W       = ADDR_W - PAGE_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CNT_W      = PAGE_W + 1;
    localparam int WAIT_W     = $clog2(CYC_LEN + 1);

    pw_state_t         state_q;
    logic [PG_W-1:0]   page_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic              start_ok, commit_ok, locked;

    // Strobe qualification against busy and each other.
    always_comb begin
        busy      = (state_q != PW_IDLE);
        start_ok  = txn_start && !busy;
        commit_ok = commit && open_q && !busy && !txn_start;
        push_en   = byte_push && open_q && !busy && !txn_start && !commit;
        clear     = start_ok;
        locked    = &page_q[PG_W-1 -: 3];
    end

    // Copy-phase addressing and merge of latch over old data.
    always_comb begin
        lat_idx     = cnt_q[PAGE_W-1:0] - 1'b1;
        int_rd_addr = {page_q, cnt_q[PAGE_W-1:0]};
        wr_addr     = {page_q, lat_idx};
        wr_data     = lat_dirty ? lat_byte : old_byte;
        wr_en       = (state_q == PW_COPY) && (cnt_q != '0) && !locked;
    end

    // Transaction open flag and page number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            page_q <= '0;
        end else if (start_ok) begin
            open_q <= 1'b1;
            page_q <= start_addr[ADDR_W-1:PAGE_W];
        end else if (commit_ok) begin
            open_q <= 1'b0;
        end
    end

    // Phase sequencing and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PW_IDLE;
            cnt_q   <= '0;
            wcnt_q  <= '0;
        end else begin
            case (state_q)
                PW_IDLE: if (commit_ok && any_dirty) begin
                    state_q <= PW_COPY;
                    cnt_q   <= '0;
                end
                PW_COPY: if (cnt_q == CNT_W'(PAGE_BYTES)) begin
                    state_q <= PW_WAIT;
                    wcnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                PW_WAIT: if (wcnt_q == WAIT_W'(CYC_LEN - 1)) begin
                    state_q <= PW_IDLE;
                end else begin
                    wcnt_q <= wcnt_q + 1'b1;
                end
                default: state_q <= PW_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pwb_page_writer.sv
// Top: page write buffer with commit sequencer and protected top eighth.
// Assumes: the protocol engine issues one strobe at a time and waits for
// busy low before starting a new transaction.
module pwb_page_writer #(
    parameter int ADDR_W  = 11,
    parameter int PAGE_W  = 6,
    parameter int CYC_LEN = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_push,
    input  logic [7:0]        push_data,
    input  logic              commit,
    output logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic                   open_q, clear, push_en, any_dirty, lat_dirty, wr_en;
    logic [PAGE_W-1:0]      lat_idx, ptr_q;
    logic [(1<<PAGE_W)-1:0] dirty_q;
    logic [7:0]             lat_byte, old_byte, wr_data;
    logic [ADDR_W-1:0]      int_rd_addr, wr_addr;

    pwb_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYC_LEN(CYC_LEN)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
        .byte_push(byte_push), .commit(commit), .any_dirty(any_dirty),
        .lat_byte(lat_byte), .lat_dirty(lat_dirty), .old_byte(old_byte),
        .busy(busy), .open_q(open_q), .clear(clear), .push_en(push_en),
        .lat_idx(lat_idx), .int_rd_addr(int_rd_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    pwb_latch #(.PAGE_W(PAGE_W)) latch_i (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .start_off(start_addr[PAGE_W-1:0]), .push_en(push_en),
        .push_byte(push_data), .rd_idx(lat_idx), .rd_byte(lat_byte),
        .rd_dirty(lat_dirty), .any_dirty(any_dirty), .ptr_q(ptr_q),
        .dirty_q(dirty_q)
    );

    pwb_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .rd_addr(rd_addr), .rd_data(rd_data),
        .int_rd_addr(int_rd_addr), .old_byte(old_byte),
        .we(wr_en), .wa(wr_addr), .wd(wr_data)
    );
endmodule

// File: rtl/pwb_checker.sv
// Protocol and timing properties of the page writer, bound to the top.
module pwb_checker #(
    parameter int ADDR_W  = 11,
    parameter int PAGE_W  = 6,
    parameter int CYC_LEN = 500000
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy,
    input logic                   txn_start,
    input logic                   byte_push,
    input logic                   commit,
    input logic                   open_q,
    input logic                   any_dirty,
    input logic [(1<<PAGE_W)-1:0] dirty_q,
    input logic [PAGE_W-1:0]      ptr_q,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr
);
    localparam int TOTAL = (1 << PAGE_W) + 1 + CYC_LEN;
    localparam int LEN_W = $clog2(TOTAL + 2) + 1;

    logic [LEN_W-1:0] len_q;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= busy ? len_q + 1'b1 : '0;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !busy);

    a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_push && open_q && !busy && !txn_start && !commit)
        |=> ptr_q == PAGE_W'($past(ptr_q) + 1'b1));

    a_r5_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && open_q && !busy && !txn_start && any_dirty) |=> busy);

    a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> len_q == LEN_W'(TOTAL));

    a_r7_locked_zone: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !(&wr_addr[ADDR_W-1 -: 3]));

    a_r8_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !busy && !any_dirty) |=> !busy);

    a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(dirty_q) && $stable(ptr_q)));

    a_r10_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start && !busy) |=> !any_dirty);
endmodule

bind pwb_page_writer pwb_checker #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYC_LEN(CYC_LEN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .txn_start(txn_start),
    .byte_push(byte_push), .commit(commit), .open_q(open_q),
    .any_dirty(any_dirty), .dirty_q(dirty_q), .ptr_q(ptr_q),
    .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/pwb_page_writer_tb_top.sv
module pwb_page_writer_tb_top;
    localparam int CLK_NS  = 10;
    localparam int ADDR_W  = 11;
    localparam int CYC     = 20;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int BUSY_N  = 64 + 1 + CYC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              txn_start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              byte_push = 1'b0;
    logic [7:0]        push_data = '0;
    logic              commit = 1'b0;
    logic              busy;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] mdl [DEPTH];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_req = 1'b0;
    logic       pend_q = 1'b0;

    pwb_page_writer #(.ADDR_W(ADDR_W), .PAGE_W(6), .CYC_LEN(CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
        .byte_push(byte_push), .push_data(push_data), .commit(commit),
        .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor: pop expected bytes as read data comes out.
    always @(posedge clk) pend_q <= rd_req;
    always @(negedge clk) begin
        if (pend_q && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data === e, t, rd_data, e);
        end
    end

    // Driver: issue reads and push expectations.
    task automatic read_page(input int base, input string tag);
        for (int j = 0; j < 64; j++) begin
            tick();
            rd_addr = ADDR_W'(base + j);
            rd_req  = 1'b1;
            exp_q.push_back(mdl[base + j]);
            tag_q.push_back(tag);
        end
        tick();
        rd_req = 1'b0;
        tick();
        tick();
    endtask

    task automatic read_one(input int a, input string tag);
        tick();
        rd_addr = ADDR_W'(a);
        rd_req  = 1'b1;
        exp_q.push_back(mdl[a]);
        tag_q.push_back(tag);
        tick();
        rd_req = 1'b0;
        tick();
        tick();
    endtask

    // One write transaction; poke issues strobes during busy (R9).
    task automatic write_txn(input int a, input int n, input int seed, input bit poke);
        logic [7:0] lat [64];
        bit dty [64];
        int p;
        int base;
        int cnt;
        p = a % 64;
        base = a - p;
        for (int j = 0; j < 64; j++) dty[j] = 1'b0;
        tick();
        txn_start = 1'b1;
        start_addr = ADDR_W'(a);
        tick();
        txn_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_push = 1'b1;
            push_data = 8'(seed + i);
            lat[p] = 8'(seed + i);
            dty[p] = 1'b1;
            p = (p + 1) % 64;
            tick();
        end
        byte_push = 1'b0;
        commit = 1'b1;
        tick();
        commit = 1'b0;
        if (n > 0) begin
            cnt = 0;
            forever begin
                @(negedge clk);
                if (!busy) break;
                cnt++;
                if (poke) begin
                    if (cnt == 3) begin txn_start = 1'b1; start_addr = ADDR_W'(base + 9); end
                    if (cnt == 4) begin txn_start = 1'b0; byte_push = 1'b1; push_data = 8'hEE; end
                    if (cnt == 5) begin byte_push = 1'b0; commit = 1'b1; end
                    if (cnt == 6) commit = 1'b0;
                end
            end
            check(cnt == BUSY_N, poke ? "R9 busy not extended" : "R5 busy length", cnt, BUSY_N);
            if (base / 256 != 7) begin
                for (int j = 0; j < 64; j++) if (dty[j]) mdl[base + j] = lat[j];
            end
        end else begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                check(busy == 1'b0, "R8 empty commit busy", busy, 0);
            end
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'(i) ^ 8'h5A;
        tick();
        tick();
        @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        tick();
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        read_one(5, "R2 init byte");
        read_one(DEPTH - 1, "R2 init protected byte");
        // R1: no transaction open after reset, push+commit does nothing
        tick();
        byte_push = 1'b1; push_data = 8'h11;
        tick();
        byte_push = 1'b0; commit = 1'b1;
        tick();
        commit = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(busy == 1'b0, "R1 no open txn", busy, 0);
        end

        write_txn(12'h045, 1, 8'h3C, 1'b0);
        read_page(12'h040, "R6 single byte page");

        write_txn(12'h090, 64, 8'h80, 1'b0);
        read_page(12'h080, "R3 wrap in page");
        read_page(12'h0C0, "R3 next page untouched");

        write_txn(12'h0C0, 70, 8'h10, 1'b0);
        read_page(12'h0C0, "R4 overflow overwrite");

        write_txn(12'h200, 0, 8'h00, 1'b0);
        read_page(12'h200, "R8 empty commit array");

        write_txn(12'h745, 5, 8'hA0, 1'b0);
        read_page(12'h740, "R7 protected page");

        write_txn(12'h102, 1, 8'h55, 1'b1);
        // R9: the start during busy opened nothing
        tick();
        byte_push = 1'b1; push_data = 8'h77;
        tick();
        byte_push = 1'b0; commit = 1'b1;
        tick();
        commit = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(busy == 1'b0, "R9 start during busy ignored", busy, 0);
        end
        read_page(12'h100, "R9 strobes during busy");

        write_txn(12'h047, 1, 8'hC7, 1'b0);
        read_page(12'h040, "R10 mask cleared");

        summary();
    end
endmodule